// File: doc/BRIEF.md
# Card Command-Line Host Sequencer

This block is the host end of a single-wire, bidirectional command line of the kind used by memory cards. When it is ready and sees a start request, it drives a 48-bit command frame onto the line, most significant bit first. The frame holds a start bit, a host-direction bit, the command index, a 32-bit argument, a 7-bit CRC and a stop bit. After the stop bit it releases the line and waits for the card's response start bit. It then shifts in a response of the selected length and reports the payload, a CRC verdict or a timeout.

Between transactions the block holds off the next command for a minimum gap. The gap is set by how the previous transaction ended: a received response, a command with no response, or an unanswered command in identification mode. In the last case the gap is stretched by the length of a long response. The command line is pulled high outside the block. `cmd_o`/`cmd_oe_o` feed a tristate pad, and `cmd_i` is the pad's input.

Top module: `cmdline_host`

## Requirements
- R1: After reset, `ready_o`=1, and `cmd_oe_o`, `done_o`, `crc_err_o`, `timeout_o` and `rsp_o` are all 0.
- R2: When `start_i` is high with `ready_o` high at a clock edge, the block drives 48 bits from the next cycle on, one per cycle, with `cmd_oe_o`=1. The bits are, MSB first: 0, 1, `idx_i[5:0]`, `arg_i[31:0]`, CRC7, 1. `cmd_oe_o` falls in the cycle after the stop bit.
- R3: The command CRC7 uses the polynomial x^7+x^3+1 (feedback taps 0x09). It starts from zero and runs over the first 40 frame bits in line order.
- R4: After the stop bit the line is released. A 0 on `cmd_i` counts as a response start bit only from the N_CR-th released cycle on (cycle count starting at 0). Earlier zeros are ignored.
- R5: If no start bit is seen in released cycles 0 to 63, `done_o` pulses with `timeout_o`=1. This is 64 cycles after the stop-bit cycle. A start bit in cycle 63 is still accepted.
- R6: `rsp_type_i` values: 0 = no response, 1 = 48-bit response with CRC, 2 = 136-bit response, 3 = 48-bit response without CRC check. For the 48-bit types, `rsp_o` holds the whole frame zero-extended, including the start bit at bit 47. For type 2, `rsp_o` holds the 128 frame bits that follow the 8-bit header.
- R7: `crc_err_o` is set when the received frame bits [7:1] differ from the CRC7 of the frame. For type 1 the CRC runs over frame bits [47:8]; for type 2 it runs over frame bits [127:8]. Type 3 never sets `crc_err_o`.
- R8: After a response ends, `ready_o` stays low for exactly N_RC cycles, counted from the `done_o` cycle.
- R9: After a type-0 command, or a timeout with `id_mode_i`=0, `ready_o` stays low for exactly N_CC cycles.
- R10: After a timeout with `id_mode_i`=1, `ready_o` stays low for exactly N_CC+136 cycles.
- R11: `done_o` is a one-cycle pulse. The results stay stable until the next accepted start. `start_i` has no effect while `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when ready_o is high |
| idx_i | input | 6 | Command index |
| arg_i | input | 32 | Command argument |
| rsp_type_i | input | 2 | Response type select |
| id_mode_i | input | 1 | 1 = identification mode |
| cmd_i | input | 1 | Command line level seen at the pad |
| cmd_o | output | 1 | Line drive value |
| cmd_oe_o | output | 1 | Line drive enable |
| ready_o | output | 1 | A new command may start |
| rsp_o | output | 128 | Captured response |
| crc_err_o | output | 1 | Response CRC mismatch |
| timeout_o | output | 1 | No response start bit seen |
| done_o | output | 1 | Transaction finished pulse |

## Verification
The first command bit appears in the cycle after start is accepted, so the bench samples it at the falling edge that follows the start edge. It then samples every following falling edge for 48 bits. A response bit driven at a falling edge is taken on the next rising edge, so `done_o` and the results are checked one falling edge after the last bit; a timeout is checked on the 65th falling edge after the stop bit. Gap lengths are counted as the number of falling edges with `ready_o` low, starting at the `done_o` edge, so each of N_RC, N_CC and N_CC+136 is compared as an exact cycle count.

// File: rtl/cmdline_pkg.sv
package cmdline_pkg;
  localparam int unsigned CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_SHORT      = 2'd1,
    RSP_LONG       = 2'd2,
    RSP_SHORT_NOCRC = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } seq_state_e;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  endfunction
endpackage

// File: rtl/cmdline_tx.sv
module cmdline_tx
  import cmdline_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned ARG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic             bit_o
);
  localparam int unsigned HEAD_W  = 2 + IDX_W + ARG_W;
  localparam int unsigned FRAME_W = HEAD_W + CRC_W + 1;

  logic [HEAD_W-1:0]  head;
  logic [CRC_W-1:0]   crc;
  logic [FRAME_W-1:0] sh_q;

  always_comb begin
    head = {1'b0, 1'b1, idx_i, arg_i};
    crc  = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) crc = crc7_step(crc, head[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= {head, crc, 1'b1};
    else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b1};
  end

  assign bit_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/cmdline_rx.sv
module cmdline_rx
  import cmdline_pkg::*;
#(
  parameter int unsigned RSP_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             crc_en_i,
  input  logic             bit_i,
  output logic [RSP_W-1:0] frame_o,
  output logic [CRC_W-1:0] crc_o
);
  logic [RSP_W-2:0] sh_q;
  logic [CRC_W-1:0] crc_q;

  // frame_o includes the bit on the line this cycle
  assign frame_o = {sh_q, bit_i};
  assign crc_o   = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      crc_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      crc_q <= '0;
    end else begin
      if (shift_i)  sh_q  <= frame_o[RSP_W-2:0];
      if (crc_en_i) crc_q <= crc7_step(crc_q, bit_i);
    end
  end
endmodule

// File: rtl/cmdline_gap.sv
module cmdline_gap #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] len_i,
  output logic             expired_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cmdline_host.sv
module cmdline_host
  import cmdline_pkg::*;
#(
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned ARG_W   = 32,
  parameter int unsigned LONG_W  = 136,
  parameter int unsigned N_CR    = 2,
  parameter int unsigned N_RC    = 8,
  parameter int unsigned N_CC    = 8,
  parameter int unsigned TIMEOUT = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [ARG_W-1:0]    arg_i,
  input  logic [1:0]          rsp_type_i,
  input  logic                id_mode_i,
  input  logic                cmd_i,
  output logic                cmd_o,
  output logic                cmd_oe_o,
  output logic                ready_o,
  output logic [LONG_W-9:0]   rsp_o,
  output logic                crc_err_o,
  output logic                timeout_o,
  output logic                done_o
);
  localparam int unsigned FRAME_W      = 2 + IDX_W + ARG_W + CRC_W + 1;
  localparam int unsigned RSP_W        = LONG_W - 8;
  localparam int unsigned SHORT_CRC_HI = FRAME_W - CRC_W - 2;
  localparam int unsigned LONG_CRC_LO  = 8;
  localparam int unsigned LONG_CRC_HI  = LONG_W - CRC_W - 2;
  localparam int unsigned CNT_MAX      = (LONG_W > TIMEOUT) ? LONG_W : TIMEOUT;
  localparam int unsigned CNT_W        = $clog2(CNT_MAX + 1);
  localparam int unsigned GAP_MAX      = (N_CC + LONG_W > N_RC) ? N_CC + LONG_W : N_RC;
  localparam int unsigned GAP_W        = $clog2(GAP_MAX + 1);

  seq_state_e       state_q;
  rsp_kind_e        kind_q;
  logic             idm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, crc_err_q, timeout_q;
  logic [RSP_W-1:0] rsp_q;

  logic             gap_ok, accept, tx_bit;
  logic             send_end, start_seen, wait_to, rsp_last, crc_win, crc_bad;
  logic             gap_load;
  logic [GAP_W-1:0] gap_len;
  logic [RSP_W-1:0] rx_frame;
  logic [CRC_W-1:0] rx_crc;

  assign ready_o  = (state_q == ST_IDLE) && gap_ok;
  assign accept   = start_i && ready_o;
  assign cmd_oe_o = (state_q == ST_SEND);
  assign cmd_o    = cmd_oe_o ? tx_bit : 1'b1;

  assign send_end   = (state_q == ST_SEND) && (cnt_q == CNT_W'(FRAME_W - 1));
  // zeros before N_CR released cycles are not a start bit
  assign start_seen = (state_q == ST_WAIT) && (cnt_q >= CNT_W'(N_CR)) && !cmd_i;
  assign wait_to    = (state_q == ST_WAIT) && !start_seen && (cnt_q == CNT_W'(TIMEOUT - 1));
  assign rsp_last   = (state_q == ST_RECV) &&
                      (cnt_q == ((kind_q == RSP_LONG) ? CNT_W'(LONG_W - 1) : CNT_W'(FRAME_W - 1)));
  assign crc_win    = (state_q == ST_RECV) &&
                      ((kind_q == RSP_LONG) ? (cnt_q >= CNT_W'(LONG_CRC_LO) && cnt_q <= CNT_W'(LONG_CRC_HI))
                                            : (cnt_q <= CNT_W'(SHORT_CRC_HI)));
  assign crc_bad    = (kind_q != RSP_SHORT_NOCRC) && (rx_crc != rx_frame[CRC_W:1]);

  assign gap_load = (send_end && kind_q == RSP_NONE) || wait_to || rsp_last;
  assign gap_len  = rsp_last            ? GAP_W'(N_RC) :
                    (wait_to && idm_q)  ? GAP_W'(N_CC + LONG_W) : GAP_W'(N_CC);

  cmdline_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk_i, .rst_ni, .load_i(accept), .shift_i(state_q == ST_SEND),
    .idx_i, .arg_i, .bit_o(tx_bit)
  );

  cmdline_rx #(.RSP_W(RSP_W)) u_rx (
    .clk_i, .rst_ni, .clear_i(start_seen), .shift_i(state_q == ST_RECV),
    .crc_en_i(crc_win), .bit_i(cmd_i), .frame_o(rx_frame), .crc_o(rx_crc)
  );

  cmdline_gap #(.GAP_W(GAP_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .len_i(gap_len), .expired_o(gap_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RSP_NONE;
      idm_q     <= 1'b0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      crc_err_q <= 1'b0;
      timeout_q <= 1'b0;
      rsp_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_SEND;
          cnt_q     <= '0;
          kind_q    <= rsp_kind_e'(rsp_type_i);
          idm_q     <= id_mode_i;
          rsp_q     <= '0;
          crc_err_q <= 1'b0;
          timeout_q <= 1'b0;
        end
        ST_SEND: begin
          if (send_end) begin
            cnt_q <= '0;
            if (kind_q == RSP_NONE) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (start_seen) begin
            state_q <= ST_RECV;
            cnt_q   <= CNT_W'(1);
          end else if (wait_to) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            timeout_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RECV: begin
          if (rsp_last) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            crc_err_q <= crc_bad;
            rsp_q     <= (kind_q == RSP_LONG) ? rx_frame : RSP_W'(rx_frame[FRAME_W-1:0]);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign crc_err_o = crc_err_q;
  assign timeout_o = timeout_q;
  assign rsp_o     = rsp_q;
endmodule

// File: rtl/cmdline_host_chk.sv
module cmdline_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic cmd_o,
  input logic cmd_oe_o,
  input logic done_o,
  input logic crc_err_o,
  input logic timeout_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> (cmd_oe_o && !cmd_o));

  // R2
  dir_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_oe_o) |=> (cmd_oe_o && cmd_o));

  // R2
  stop_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_oe_o) |-> $past(cmd_o));

  // R11
  idle_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cmd_oe_o);

  // R5
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(timeout_o && crc_err_o));

  // R8
  gap_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
endmodule

bind cmdline_host cmdline_host_chk u_chk (.*);

// File: tb/tb_cmdline_host.sv
module tb_cmdline_host;
  localparam int N_CR = 2, N_RC = 8, N_CC = 8, TO = 64;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         start_i = 1'b0, id_mode_i = 1'b0, cmd_i = 1'b1;
  logic [5:0]   idx_i = '0;
  logic [31:0]  arg_i = '0;
  logic [1:0]   rsp_type_i = '0;
  logic         cmd_o, cmd_oe_o, ready_o, crc_err_o, timeout_o, done_o;
  logic [127:0] rsp_o;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmdline_host #(.N_CR(N_CR), .N_RC(N_RC), .N_CC(N_CC), .TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni, .start_i, .idx_i, .arg_i, .rsp_type_i, .id_mode_i,
    .cmd_i, .cmd_o, .cmd_oe_o, .ready_o, .rsp_o, .crc_err_o, .timeout_o, .done_o
  );

  task automatic check(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7_ref(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    logic fb;
    for (int i = hi; i >= lo; i--) begin
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic count_gap(input int exp, input string tag, input logic [127:0] held);
    int cnt = 0;
    while (!ready_o) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == exp, tag, cnt, exp);
    check(rsp_o == held, "R11 result held", rsp_o, held);
  endtask

  // delay < 0: card stays silent
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] typ,
                         input bit idm, input int delay, input bit corrupt, input bit spur);
    logic [47:0]  exp_f, got;
    logic [135:0] rf;
    logic [127:0] exp_rsp;
    bit           exp_err;
    int           len, cnt;
    exp_f[47:8] = {2'b01, idx, arg};
    exp_f[7:1]  = crc7_ref({88'b0, exp_f}, 47, 8);
    exp_f[0]    = 1'b1;
    while (!ready_o) @(negedge clk);
    idx_i = idx; arg_i = arg; rsp_type_i = typ; id_mode_i = idm;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 48; k++) begin
      got[47-k] = cmd_o;
      if (!cmd_oe_o) check(1'b0, "R2 drive enable", 0, 1);
      if (k < 47) @(negedge clk);
    end
    check(got == exp_f, "R2 frame", got, exp_f);
    check(got[7:1] == exp_f[7:1], "R3 crc", got[7:1], exp_f[7:1]);
    @(negedge clk);
    check(cmd_oe_o == 1'b0, "R4 release", cmd_oe_o, 0);
    if (typ == 2'd0) begin
      check(done_o && !timeout_o, "R9 done no-rsp", {done_o, timeout_o}, 2'b10);
      count_gap(N_CC, "R9 gap", '0);
      return;
    end
    if (delay < 0) begin
      cnt = 1;
      while (!done_o && cnt < 200) begin
        @(negedge clk);
        cnt++;
      end
      check(cnt == TO + 1, "R5 timeout cycle", cnt, TO + 1);
      check(timeout_o && !crc_err_o, "R5 timeout flag", {timeout_o, crc_err_o}, 2'b10);
      if (idm) count_gap(N_CC + 136, "R10 id gap", '0);
      else     count_gap(N_CC, "R9 gap timeout", '0);
      return;
    end
    rf = '0;
    exp_err = 1'b0;
    if (typ == 2'd2) begin
      len = 136;
      rf[135:128] = {2'b00, 6'h3f};
      rf[127:8]   = {$urandom, $urandom, $urandom, $urandom};
      rf[7:1]     = crc7_ref(rf, 127, 8);
      rf[0]       = 1'b1;
      if (corrupt) begin rf[3] = ~rf[3]; exp_err = 1'b1; end
      exp_rsp = rf[127:0];
    end else begin
      len = 48;
      if (typ == 2'd1) begin
        rf[47:8] = {2'b00, 6'($urandom), 32'($urandom)};
        rf[7:1]  = crc7_ref(rf, 47, 8);
        if (corrupt) begin rf[1] = ~rf[1]; exp_err = 1'b1; end
      end else begin
        rf[47:8] = {2'b00, 6'h3f, 32'($urandom)};
        rf[7:1]  = 7'h7f;
      end
      rf[0] = 1'b1;
      exp_rsp = {80'b0, rf[47:0]};
    end
    for (int d = 0; d < delay; d++) begin
      cmd_i   = (spur && d < N_CR) ? 1'b0 : 1'b1;
      start_i = (d == 0);
      @(negedge clk);
      start_i = 1'b0;
      if (d == 0) check(cmd_oe_o == 1'b0, "R11 start ignored", cmd_oe_o, 0);
    end
    for (int b = 0; b < len; b++) begin
      cmd_i = rf[len-1-b];
      @(negedge clk);
    end
    cmd_i = 1'b1;
    check(done_o == 1'b1, "R6 done after response", done_o, 1);
    check(rsp_o == exp_rsp, "R6 response", rsp_o, exp_rsp);
    check(crc_err_o == exp_err, "R7 crc flag", crc_err_o, exp_err);
    check(timeout_o == 1'b0, "R5 no timeout", timeout_o, 0);
    if (spur) check(rsp_o == exp_rsp, "R4 early zeros ignored", rsp_o, exp_rsp);
    count_gap(N_RC, "R8 gap", exp_rsp);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    check(ready_o && !cmd_oe_o && !done_o, "R1 reset ctl", {ready_o, cmd_oe_o, done_o}, 3'b100);
    check(!crc_err_o && !timeout_o && rsp_o == '0, "R1 reset results", rsp_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run_cmd(6'd0,  32'h0,          2'd0, 1'b1, 0,  1'b0, 1'b0);
    run_cmd(6'd1,  32'h00ff8000,   2'd3, 1'b1, N_CR, 1'b0, 1'b0);
    run_cmd(6'd2,  32'h0,          2'd2, 1'b1, 5,  1'b0, 1'b0);
    run_cmd(6'd2,  32'h0,          2'd2, 1'b0, 4,  1'b1, 1'b0);
    run_cmd(6'd13, 32'hdeadbeef,   2'd1, 1'b0, N_CR, 1'b0, 1'b1);
    run_cmd(6'd17, 32'h12345678,   2'd1, 1'b0, TO - 1, 1'b1, 1'b0);
    run_cmd(6'd2,  32'h0,          2'd2, 1'b1, -1, 1'b0, 1'b0);
    run_cmd(6'd7,  32'hffffffff,   2'd1, 1'b0, -1, 1'b0, 1'b0);
    for (int n = 0; n < 40; n++) begin
      logic [1:0] t = 2'($urandom);
      int dl = N_CR + int'($urandom % 20);
      if (t != 2'd0 && ($urandom % 8) == 0) dl = -1;
      run_cmd(6'($urandom), 32'($urandom), t, 1'($urandom), dl,
              ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule